// File: doc/BRIEF.md
# Synchronized Hardware Loop Stack

This block holds the nesting state for a sequencer's zero-overhead loops. It is built as two stacks that move together. One lane stores loop end addresses and the other stores loop counts. A single occupancy pointer serves both lanes, so the two always hold the same number of entries. The sequencer pushes one entry into both lanes when a loop starts or when an explicit push is executed. It removes an entry on an explicit pop, or when loop-end logic signals that the final iteration is about to end.

Software can read and rewrite the top address entry and the top count entry through plain register ports. Those accesses never move the pointer. When no entry is occupied, both top outputs read as all ones.

Two sticky flags are shared by both lanes, one for overflow and one for empty, and a single strobe clears both. The overflow flag also drives an interrupt request that a mask input can suppress. All interfaces here are per-cycle control strobes issued by the sequencer, so there is no valid/ready handshake and no back-pressure: every strobe is acted on in the cycle it is presented.

Top module: `lpstk_top`

## Requirements
- R1: The stack holds at most DEPTH (default 6) entries. Entries come back last-in first-out, and each address is paired with the count pushed beside it.
- R2: A push stores `push_addr_i` and `push_cnt_i` as the new top entry. The top outputs show them in the cycle after the clock edge that samples the push.
- R3: A pop is requested by `pop_i`, by `term_pop_i`, or by both together. Any of these removes exactly one entry.
- R4: A push without a pop while DEPTH entries are held is an overflow. It sets `ovf_flag_o`, leaves the pointer at DEPTH and leaves every stored entry unchanged. The flag then stays at 1 until it is cleared.
- R5: `ovf_irq_o` is 1 exactly when `ovf_flag_o` is 1 and `ovf_mask_i` is 0.
- R6: While no entry is held, `top_addr_o` and `top_cnt_o` read all ones.
- R7: `addr_wr_i` replaces only the top address and `cnt_wr_i` replaces only the top count, and neither moves the pointer. Both writes are ignored when the stack is empty, and both are ignored in a cycle that carries a push or a pop request.
- R8: `empty_flag_o` is 1 after reset. It is set again when a pop takes the occupancy from 1 to 0. A pop on an empty stack changes nothing and does not set the flag.
- R9: `sticky_clr_i` clears both sticky flags. If a flag is being set in the same cycle, the set wins.
- R10: A push together with a pop on a non-empty stack replaces the top entry with the pushed values and keeps the occupancy unchanged. On an empty stack the same pair acts as a plain push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push strobe |
| push_addr_i | input | AW | Loop end address to push |
| push_cnt_i | input | CW | Loop count to push |
| pop_i | input | 1 | Explicit pop strobe |
| term_pop_i | input | 1 | Pop request from loop termination |
| addr_wr_i | input | 1 | Write strobe for the top address entry |
| addr_wdata_i | input | AW | Data for the top address entry |
| cnt_wr_i | input | 1 | Write strobe for the top count entry |
| cnt_wdata_i | input | CW | Data for the top count entry |
| sticky_clr_i | input | 1 | Clears both sticky flags |
| ovf_mask_i | input | 1 | Masks the overflow interrupt |
| top_addr_o | output | AW | Top address entry, all ones when empty |
| top_cnt_o | output | CW | Top count entry, all ones when empty |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| empty_flag_o | output | 1 | Sticky empty flag |
| ovf_irq_o | output | 1 | Overflow interrupt request |

## Verification
Push and pop can arrive in the same cycle, for example when one loop ends and the next one starts at once. A register write can also coincide with either of them. The bench provokes these collisions in directed cases: a swap at full depth, a swap with a concurrent register write, and a push-pop pair on an empty stack. It also mixes them heavily in a seeded random run, and it compares the top values and flags every cycle against a bench model that follows the stated priorities. A flag clear in the same cycle as an overflowing push, and a pop on an empty stack after the empty flag has been cleared, are checked separately.

// File: rtl/lpstk_pkg.sv
package lpstk_pkg;
  // Per-cycle stack action chosen by the control unit
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_PUSH,
    ACT_DROP,
    ACT_SWAP,
    ACT_SAT
  } act_e;
endpackage

// File: rtl/lpstk_ctrl.sv
module lpstk_ctrl
  import lpstk_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          clr_i,
  output act_e          act_o,
  output logic [PW-1:0] ptr_o,
  output logic          ovf_o,
  output logic          empty_o
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);
  localparam logic [PW-1:0] ONE  = PW'(1);

  logic [PW-1:0] ptr_q;
  logic          ovf_q;
  logic          empty_q;
  act_e          act;

  // Priority: swap, saturate, push, drop
  always_comb begin
    if (push_i && pop_i && ptr_q != '0) act = ACT_SWAP;
    else if (push_i && ptr_q == FULL)   act = ACT_SAT;
    else if (push_i)                    act = ACT_PUSH;
    else if (pop_i && ptr_q != '0)      act = ACT_DROP;
    else                                act = ACT_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      ovf_q   <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      case (act)
        ACT_PUSH: ptr_q <= ptr_q + ONE;
        ACT_DROP: ptr_q <= ptr_q - ONE;
        default:  ptr_q <= ptr_q;
      endcase
      // set has priority over clear
      if (act == ACT_SAT)  ovf_q <= 1'b1;
      else if (clr_i)      ovf_q <= 1'b0;
      if (act == ACT_DROP && ptr_q == ONE) empty_q <= 1'b1;
      else if (clr_i)                      empty_q <= 1'b0;
    end
  end

  assign act_o   = act;
  assign ptr_o   = ptr_q;
  assign ovf_o   = ovf_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/lpstk_lane.sv
module lpstk_lane
  import lpstk_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int W     = 32,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  act_e          act_i,
  input  logic [PW-1:0] ptr_i,
  input  logic [W-1:0]  push_d_i,
  input  logic          edit_i,
  input  logic [W-1:0]  edit_d_i,
  output logic [W-1:0]  top_o
);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] top_ptr;
  logic [IW-1:0] top_idx;
  logic [IW-1:0] new_idx;
  logic          nonempty;

  assign nonempty = (ptr_i != '0);
  assign top_ptr  = ptr_i - PW'(1);
  assign top_idx  = top_ptr[IW-1:0];
  assign new_idx  = ptr_i[IW-1:0];

  always_ff @(posedge clk) begin
    case (act_i)
      ACT_PUSH: mem[new_idx] <= push_d_i;
      ACT_SWAP: mem[top_idx] <= push_d_i;
      ACT_IDLE: if (edit_i && nonempty) mem[top_idx] <= edit_d_i;
      default:  ;
    endcase
  end

  assign top_o = nonempty ? mem[top_idx] : '1;
endmodule

// File: rtl/lpstk_top.sv
module lpstk_top
  import lpstk_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int AW    = 32,
  parameter int CW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [CW-1:0] push_cnt_i,
  input  logic          pop_i,
  input  logic          term_pop_i,
  input  logic          addr_wr_i,
  input  logic [AW-1:0] addr_wdata_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic          sticky_clr_i,
  input  logic          ovf_mask_i,
  output logic [AW-1:0] top_addr_o,
  output logic [CW-1:0] top_cnt_o,
  output logic          ovf_flag_o,
  output logic          empty_flag_o,
  output logic          ovf_irq_o
);
  localparam int PW = $clog2(DEPTH + 1);

  act_e          act;
  logic [PW-1:0] ptr_q;
  logic          pop_any;

  assign pop_any = pop_i | term_pop_i;

  lpstk_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push_i),
    .pop_i   (pop_any),
    .clr_i   (sticky_clr_i),
    .act_o   (act),
    .ptr_o   (ptr_q),
    .ovf_o   (ovf_flag_o),
    .empty_o (empty_flag_o)
  );

  lpstk_lane #(.DEPTH(DEPTH), .W(AW), .PW(PW)) u_addr_lane (
    .clk      (clk),
    .act_i    (act),
    .ptr_i    (ptr_q),
    .push_d_i (push_addr_i),
    .edit_i   (addr_wr_i),
    .edit_d_i (addr_wdata_i),
    .top_o    (top_addr_o)
  );

  lpstk_lane #(.DEPTH(DEPTH), .W(CW), .PW(PW)) u_cnt_lane (
    .clk      (clk),
    .act_i    (act),
    .ptr_i    (ptr_q),
    .push_d_i (push_cnt_i),
    .edit_i   (cnt_wr_i),
    .edit_d_i (cnt_wdata_i),
    .top_o    (top_cnt_o)
  );

  assign ovf_irq_o = ovf_flag_o & ~ovf_mask_i;
endmodule

// File: rtl/lpstk_chk.sv
module lpstk_chk #(
  parameter int DEPTH = 6,
  parameter int AW    = 32,
  parameter int PW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_i,
  input logic          term_pop_i,
  input logic          addr_wr_i,
  input logic          sticky_clr_i,
  input logic          ovf_mask_i,
  input logic [PW-1:0] ptr_i,
  input logic [AW-1:0] top_addr_o,
  input logic          ovf_flag_o,
  input logic          empty_flag_o,
  input logic          ovf_irq_o
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);
  logic pop_any;
  assign pop_any = pop_i | term_pop_i;

  // R1
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_i <= FULL);

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_any && ptr_i == FULL) |=> (ovf_flag_o && ptr_i == FULL));

  // R4
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !sticky_clr_i) |=> ovf_flag_o);

  // R5
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_mask_i |-> !ovf_irq_o);

  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_i == '0) |-> (top_addr_o == '1));

  // R7
  wr_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr_i && !push_i && !pop_any) |=> $stable(ptr_i));

  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_i == '0 && pop_any && !push_i && !sticky_clr_i)
      |=> (ptr_i == '0 && empty_flag_o == $past(empty_flag_o)));

  // R10
  swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_any && ptr_i != '0) |=> $stable(ptr_i));
endmodule

bind lpstk_top lpstk_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .term_pop_i   (term_pop_i),
  .addr_wr_i    (addr_wr_i),
  .sticky_clr_i (sticky_clr_i),
  .ovf_mask_i   (ovf_mask_i),
  .ptr_i        (ptr_q),
  .top_addr_o   (top_addr_o),
  .ovf_flag_o   (ovf_flag_o),
  .empty_flag_o (empty_flag_o),
  .ovf_irq_o    (ovf_irq_o)
);

// File: tb/test_lpstk_top.sv
module test_lpstk_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, term_pop_i = 0;
  logic [31:0] push_addr_i = 0, push_cnt_i = 0;
  logic        addr_wr_i = 0, cnt_wr_i = 0;
  logic [31:0] addr_wdata_i = 0, cnt_wdata_i = 0;
  logic        sticky_clr_i = 0, ovf_mask_i = 0;
  logic [31:0] top_addr_o, top_cnt_o;
  logic        ovf_flag_o, empty_flag_o, ovf_irq_o;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_a [DEPTH];
  logic [31:0] m_c [DEPTH];
  int          m_ptr;
  bit          m_ovf, m_emp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpstk_top #(.DEPTH(DEPTH), .AW(32), .CW(32)) i_lpstk_top (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .push_cnt_i(push_cnt_i), .pop_i(pop_i), .term_pop_i(term_pop_i),
    .addr_wr_i(addr_wr_i), .addr_wdata_i(addr_wdata_i), .cnt_wr_i(cnt_wr_i),
    .cnt_wdata_i(cnt_wdata_i), .sticky_clr_i(sticky_clr_i), .ovf_mask_i(ovf_mask_i),
    .top_addr_o(top_addr_o), .top_cnt_o(top_cnt_o), .ovf_flag_o(ovf_flag_o),
    .empty_flag_o(empty_flag_o), .ovf_irq_o(ovf_irq_o)
  );

  function automatic logic [31:0] exp_top_a();
    return (m_ptr == 0) ? 32'hFFFF_FFFF : m_a[m_ptr-1];
  endfunction
  function automatic logic [31:0] exp_top_c();
    return (m_ptr == 0) ? 32'hFFFF_FFFF : m_c[m_ptr-1];
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "top_addr", top_addr_o, exp_top_a());
    cmp(tag, "top_cnt", top_cnt_o, exp_top_c());
    cmp(tag, "ovf_flag", {31'd0, ovf_flag_o}, {31'd0, m_ovf});
    cmp(tag, "empty_flag", {31'd0, empty_flag_o}, {31'd0, m_emp});
    cmp(tag, "ovf_irq", {31'd0, ovf_irq_o}, {31'd0, m_ovf & ~ovf_mask_i});
  endtask

  // Model of one clock edge, from the requirements
  task automatic model_edge();
    bit pa, set_o, set_e;
    pa = pop_i | term_pop_i;
    set_o = 0; set_e = 0;
    if (push_i && pa && m_ptr > 0) begin            // R10 swap
      m_a[m_ptr-1] = push_addr_i; m_c[m_ptr-1] = push_cnt_i;
    end else if (push_i) begin
      if (m_ptr < DEPTH) begin                      // R2
        m_a[m_ptr] = push_addr_i; m_c[m_ptr] = push_cnt_i; m_ptr++;
      end else set_o = 1;                           // R4
    end else if (pa) begin
      if (m_ptr > 0) begin                          // R3
        m_ptr--;
        if (m_ptr == 0) set_e = 1;                  // R8
      end
    end else if (m_ptr > 0) begin                   // R7
      if (addr_wr_i) m_a[m_ptr-1] = addr_wdata_i;
      if (cnt_wr_i)  m_c[m_ptr-1] = cnt_wdata_i;
    end
    m_ovf = set_o ? 1'b1 : (sticky_clr_i ? 1'b0 : m_ovf);   // R9
    m_emp = set_e ? 1'b1 : (sticky_clr_i ? 1'b0 : m_emp);
  endtask

  task automatic step(input string tag, input bit ps, input bit pp, input bit tp,
                      input bit aw, input bit cw, input bit cl);
    push_i = ps; pop_i = pp; term_pop_i = tp;
    addr_wr_i = aw; cnt_wr_i = cw; sticky_clr_i = cl;
    push_addr_i = $urandom; push_cnt_i = $urandom;
    addr_wdata_i = $urandom; cnt_wdata_i = $urandom;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ptr = 0; m_ovf = 0; m_emp = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check_all("R8 R6 reset");

    step("R7 write while empty", 0, 0, 0, 1, 1, 0);
    step("R9 clear empty", 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH; i++) step("R1 R2 fill", 1, 0, 0, 0, 0, 0);
    step("R4 push at full", 1, 0, 0, 0, 0, 0);
    step("R4 second overflow push", 1, 0, 0, 0, 0, 0);
    ovf_mask_i = 1'b1;
    step("R5 masked", 0, 0, 0, 0, 0, 0);
    ovf_mask_i = 1'b0;
    step("R9 clear with overflow push", 1, 0, 0, 0, 0, 1);
    step("R9 clear alone", 0, 0, 0, 0, 0, 1);
    step("R10 swap at full", 1, 1, 0, 0, 0, 0);
    step("R7 write top addr", 0, 0, 0, 1, 0, 0);
    step("R7 write top cnt", 0, 0, 0, 0, 1, 0);
    step("R7 R10 write during swap", 1, 0, 1, 1, 1, 0);
    step("R7 write during pop", 0, 1, 0, 1, 1, 0);
    step("R3 term pop", 0, 0, 1, 0, 0, 0);
    step("R3 both pops", 0, 1, 1, 0, 0, 0);
    while (m_ptr > 0) step("R1 R3 R8 drain", 0, 1, 0, 0, 0, 0);
    step("R9 clear empty", 0, 0, 0, 0, 0, 1);
    step("R8 pop on empty", 0, 1, 1, 0, 0, 0);
    step("R10 push pop on empty", 1, 1, 0, 0, 0, 0);
    step("R6 R8 pop to empty", 0, 0, 1, 0, 0, 0);

    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 32) == 0) ovf_mask_i = ~ovf_mask_i;
      step("R1 R2 R3 R4 R7 R10 random",
           ($urandom % 10) < 4, ($urandom % 10) < 3, ($urandom % 10) < 1,
           ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 20) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule